// File: doc/BRIEF.md
# Timeout Counter Scan Engine

This engine walks a table of per-device timeout counters held in a word memory. Each entry's counter word sits 15 words after the previous one. For each entry, the engine reads the counter and adds one, modulo 2^16. A counter that was zero is idle and is left untouched. Any other counter gets its incremented value written back, unless that value has wrapped to zero. A wrap means the device has expired, and the scan halts at that entry.

An enclosing controller pulses `start` with the address of the first counter word and the number of entries to visit. It then waits for `done`. At that point `timed_out` gives the outcome. `addr_out` and `count_out` hold the final pointer and the remaining entry count, so the controller can resume a scan after it handles an expiry. All memory traffic goes over a single-port word interface with separate read and write strobes. Each access waits for `mem_rdy`.

Top module: `tmo_scan_engine`

## Requirements
- R1: A synchronous active-high `rst` returns the engine to idle, even in the middle of a scan. While idle, `busy`, `done`, `mem_rd` and `mem_wr` are all low.
- R2: Entries are read in order: the first at `start_addr`, each later one 15 words above the previous one. A strobe and its address stay steady until the cycle in which `mem_rdy` is high, and that cycle completes the access.
- R3: A counter word read as 0x0000 (incremented value 1) is not written back, and the scan moves on to the next entry.
- R4: A counter whose incremented value is neither 0 nor 1 is written back, incremented, to the address it was read from, before the next entry is read.
- R5: A counter read as 0xFFFF ends the scan with `timed_out` = 1 and is not written. `addr_out` holds that counter's address, and `count_out` still includes that entry (it is not decremented for it).
- R6: When every entry is visited without an expiry, the scan ends with `timed_out` = 0 and `count_out` = 0. `addr_out` holds `start_addr` + 15 × `entry_count`.
- R7: A start with `entry_count` = 0 raises `done` on the next cycle with `timed_out` = 0, the start address and a count of 0, and makes no memory access.
- R8: `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse with `busy` low. A `start` pulse seen while busy is ignored.
- R9: At most one memory access is in flight: `mem_rd` and `mem_wr` are never high together.
- R10: Address arithmetic wraps modulo 2^16, so a table may run past 0xFFFF into low memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only while idle |
| start_addr | input | 16 | Address of the first counter word |
| entry_count | input | 16 | Number of entries to visit |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | 1 = stopped on an expired counter, 0 = all entries visited |
| addr_out | output | 16 | Final address register |
| count_out | output | 16 | Final remaining-count register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid when `mem_rdy` is high |
| mem_rdy | input | 1 | Access complete |

## Verification
The inline assertions check on every cycle:
- the strobes are never high together;
- a strobe and its address hold steady until ready arrives;
- no written value is 0 or 1;
- the count never steps below zero;
- `done` is a single pulse;
- a zero-count start completes at once;
- a clean finish carries a zero count.

Some results depend on memory contents and can only be shown by the bench's scenarios. These are:
- which entries were skipped or written, and with which values;
- where an expiry stops the pointer;
- how the address wraps at the top of memory;
- that a start pulse during a scan changes nothing.

// File: rtl/tmo_scan_pkg.sv
package tmo_scan_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_WRITE,
        ST_DONE
    } scan_state_e;

    // Pointer pair carried through the walk
    typedef struct packed {
        word_t addr;
        word_t left;
    } scan_ptr_t;

    function automatic word_t bump(input word_t w);
        return w + word_t'(1);
    endfunction

    function automatic word_t advance(input word_t a, input int unsigned stride);
        return a + word_t'(stride);
    endfunction

endpackage

// File: rtl/tmo_scan_fsm.sv
module tmo_scan_fsm
    import tmo_scan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        count_is_zero,
    input  logic        mem_rdy,
    input  logic        inc_zero,
    input  logic        inc_one,
    input  logic        last_entry,
    output scan_state_e state,
    output logic        load,
    output logic        capture,
    output logic        step,
    output logic        expire
);

    scan_state_e nxt;

    always_comb begin
        nxt     = state;
        load    = 1'b0;
        capture = 1'b0;
        step    = 1'b0;
        expire  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    nxt  = count_is_zero ? ST_DONE : ST_READ;
                end
            end
            ST_READ: begin
                if (mem_rdy) begin
                    capture = 1'b1;
                    nxt     = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (inc_zero) begin
                    expire = 1'b1;
                    nxt    = ST_DONE;
                end else if (inc_one) begin
                    step = 1'b1;
                    nxt  = last_entry ? ST_DONE : ST_READ;
                end else begin
                    nxt = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_rdy) begin
                    step = 1'b1;
                    nxt  = last_entry ? ST_DONE : ST_READ;
                end
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R5: an expiry never also advances the pointer
    assert_expiry_no_step_R5: assert property (@(posedge clk) disable iff (rst)
        expire |-> !step);

    // R1: the cycle after reset finds the engine idle
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == ST_IDLE));

endmodule

// File: rtl/tmo_scan_dp.sv
module tmo_scan_dp
    import tmo_scan_pkg::*;
#(
    parameter int unsigned STRIDE = 15
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  capture,
    input  logic  step,
    input  logic  expire,
    input  word_t start_addr,
    input  word_t entry_count,
    input  word_t mem_rdata,
    output word_t cur_addr,
    output word_t cur_left,
    output word_t inc_val,
    output logic  expired,
    output logic  inc_zero,
    output logic  inc_one,
    output logic  last_entry
);

    scan_ptr_t ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            inc_val <= '0;
            expired <= 1'b0;
        end else begin
            if (load) begin
                ptr.addr <= start_addr;
                ptr.left <= entry_count;
                expired  <= 1'b0;
            end else if (step) begin
                ptr.addr <= advance(ptr.addr, STRIDE);
                ptr.left <= ptr.left - word_t'(1);
            end
            if (capture) inc_val <= bump(mem_rdata);
            if (expire)  expired <= 1'b1;
        end
    end

    assign cur_addr   = ptr.addr;
    assign cur_left   = ptr.left;
    assign inc_zero   = (inc_val == '0);
    assign inc_one    = (inc_val == word_t'(1));
    assign last_entry = (ptr.left == word_t'(1));

    // R6: the remaining count never steps below zero
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        step |-> (ptr.left != '0));

endmodule

// File: rtl/tmo_scan_engine.sv
module tmo_scan_engine
    import tmo_scan_pkg::*;
#(
    parameter int unsigned STRIDE = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] start_addr,
    input  logic [WORD_W-1:0] entry_count,
    output logic              busy,
    output logic              done,
    output logic              timed_out,
    output logic [WORD_W-1:0] addr_out,
    output logic [WORD_W-1:0] count_out,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rdy
);

    scan_state_e state;
    logic  load, capture, step, expire;
    logic  inc_zero, inc_one, last_entry, expired;
    word_t cur_addr, cur_left, inc_val;

    tmo_scan_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .count_is_zero (entry_count == '0),
        .mem_rdy       (mem_rdy),
        .inc_zero      (inc_zero),
        .inc_one       (inc_one),
        .last_entry    (last_entry),
        .state         (state),
        .load          (load),
        .capture       (capture),
        .step          (step),
        .expire        (expire)
    );

    tmo_scan_dp #(.STRIDE(STRIDE)) u_dp (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .capture     (capture),
        .step        (step),
        .expire      (expire),
        .start_addr  (start_addr),
        .entry_count (entry_count),
        .mem_rdata   (mem_rdata),
        .cur_addr    (cur_addr),
        .cur_left    (cur_left),
        .inc_val     (inc_val),
        .expired     (expired),
        .inc_zero    (inc_zero),
        .inc_one     (inc_one),
        .last_entry  (last_entry)
    );

    assign busy      = (state == ST_READ) || (state == ST_EVAL) || (state == ST_WRITE);
    assign done      = (state == ST_DONE);
    assign timed_out = expired;
    assign addr_out  = cur_addr;
    assign count_out = cur_left;
    assign mem_rd    = (state == ST_READ);
    assign mem_wr    = (state == ST_WRITE);
    assign mem_addr  = cur_addr;
    assign mem_wdata = inc_val;

    // R9: never two accesses at once
    assert_single_access_R9: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R2: a read stalls with its address held until ready
    assert_read_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr)));

    // R3: idle (0 -> 1) and expired (-> 0) values are never written
    assert_wb_value_R3: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata != '0 && mem_wdata != word_t'(1)));

    // R8: done is a single pulse and busy is low alongside it
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy ##1 !done));

    // R7: an idle start with zero entries completes next cycle
    assert_zero_count_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && start && entry_count == '0) |=> (done && !timed_out));

    // R6: a clean finish leaves nothing remaining
    assert_clean_finish_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !timed_out) |-> (count_out == '0));

endmodule

// File: tb/sim_tmo_scan_engine.sv
module sim_tmo_scan_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] start_addr = '0;
    logic [15:0] entry_count = '0;
    logic        busy, done, timed_out, mem_rd, mem_wr, mem_rdy;
    logic [15:0] addr_out, count_out, mem_addr, mem_wdata, mem_rdata;

    always #10 clk = ~clk;   // 50 MHz

    tmo_scan_engine u0 (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .entry_count(entry_count), .busy(busy), .done(done),
        .timed_out(timed_out), .addr_out(addr_out), .count_out(count_out),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
    );

    // Memory model: 4096 words, address folded to 12 bits
    logic [15:0] mem  [0:4095];
    logic [15:0] emem [0:4095];
    int   lat = 0;
    int   wcnt = 0;
    int   n_rd = 0;
    int   n_wr = 0;
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;

    assign mem_rdata = mem[mem_addr[11:0]];

    always @(posedge clk) begin
        if ((mem_rd || mem_wr) && !mem_rdy) begin
            if (wcnt >= lat) begin mem_rdy <= 1'b1; wcnt <= 0; end
            else wcnt <= wcnt + 1;
        end else begin
            mem_rdy <= 1'b0;
        end
        if (mem_rdy && mem_wr) begin mem[mem_addr[11:0]] <= mem_wdata; n_wr <= n_wr + 1; end
        if (mem_rdy && mem_rd) n_rd <= n_rd + 1;
    end

    initial mem_rdy = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] n;
        logic [15:0] v0;
        logic [15:0] v1;
        logic [15:0] v2;
        logic [15:0] v3;
        logic [3:0]  lt;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{16'h0010, 16'd3, 16'h0000, 16'h0005, 16'h0000, 16'h0000, 4'd0},
        '{16'h0100, 16'd4, 16'h0007, 16'hFFFF, 16'h0002, 16'h0003, 4'd2},
        '{16'hFFF0, 16'd2, 16'h0001, 16'h7FFF, 16'h0000, 16'h0000, 4'd1},
        '{16'h0200, 16'd1, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 4'd3},
        '{16'h0300, 16'd4, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd0}
    };

    task automatic preload(input vec_t v);
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        mem[(v.a + 16'd0)  & 16'h0FFF] = v.v0;
        mem[(v.a + 16'd15) & 16'h0FFF] = v.v1;
        mem[(v.a + 16'd30) & 16'h0FFF] = v.v2;
        mem[(v.a + 16'd45) & 16'h0FFF] = v.v3;
    endtask

    // Runs one scan against a requirement-level model, optionally poking start mid-run
    task automatic run_scan(input vec_t v, input bit poke);
        logic [15:0] a, c, val;
        int er, ew, n0r, n0w, waited;
        bit to;
        for (int i = 0; i < 4096; i++) emem[i] = mem[i];
        a = v.a; c = v.n; to = 1'b0; er = 0; ew = 0;
        while (c != 0) begin
            val = emem[a[11:0]] + 16'd1;
            er++;
            if (val == 16'd0) begin to = 1'b1; break; end
            if (val != 16'd1) begin emem[a[11:0]] = val; ew++; end
            a = a + 16'd15;
            c = c - 16'd1;
        end
        lat = int'(v.lt);
        n0r = n_rd; n0w = n_wr;
        @(negedge clk);
        start_addr = v.a; entry_count = v.n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (v.n != 0) chk(busy == 1'b1, "R8", "busy after start", 32'(busy), 32'd1);
        if (poke) begin
            @(negedge clk);
            start_addr = 16'h0800; entry_count = 16'd9; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 3000) begin @(negedge clk); waited++; end
        chk(done == 1'b1, "R8", "done seen", 32'(done), 32'd1);
        chk(timed_out == to, to ? "R5" : "R6", "outcome", 32'(timed_out), 32'(to));
        chk(addr_out == a, to ? "R5" : "R10", "final address", 32'(addr_out), 32'(a));
        chk(count_out == c, to ? "R5" : "R6", "final count", 32'(count_out), 32'(c));
        chk((n_rd - n0r) == er, "R2", "reads made", 32'(n_rd - n0r), 32'(er));
        chk((n_wr - n0w) == ew, "R4", "writes made", 32'(n_wr - n0w), 32'(ew));
        for (int k = 0; k < 5; k++) begin
            logic [11:0] ix;
            ix = 12'((v.a + 16'(15 * k)) & 16'h0FFF);
            chk(mem[ix] == emem[ix], "R3", "entry contents", 32'(mem[ix]), 32'(emem[ix]));
        end
        @(negedge clk);
        chk(!done && !busy, "R8", "done single pulse", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr, "R1", "idle after reset",
            {28'd0, busy, done, mem_rd, mem_wr}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // Table-driven scans (R2..R6, R10)
        for (int t = 0; t < 5; t++) begin
            preload(VECS[t]);
            run_scan(VECS[t], 1'b0);
        end

        // R8: start while busy is ignored
        preload(VECS[1]);
        run_scan(VECS[1], 1'b1);

        // R7: zero entry count
        begin
            int r0, w0;
            r0 = n_rd; w0 = n_wr;
            start_addr = 16'h0444; entry_count = 16'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(done == 1'b1, "R7", "done next cycle", 32'(done), 32'd1);
            chk(timed_out == 1'b0, "R7", "no timeout", 32'(timed_out), 32'd0);
            chk(addr_out == 16'h0444 && count_out == 16'd0, "R7", "pointer registers",
                {addr_out, count_out}, {16'h0444, 16'd0});
            @(negedge clk);
            chk((n_rd - r0) + (n_wr - w0) == 0, "R7", "no access",
                32'((n_rd - r0) + (n_wr - w0)), 32'd0);
        end

        // R1: reset in the middle of a scan
        preload(VECS[4]);
        lat = 5;
        start_addr = 16'h0300; entry_count = 16'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr, "R1", "idle after mid-scan reset",
            {28'd0, busy, done, mem_rd, mem_wr}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !done, "R1", "stays idle", {30'd0, busy, done}, 32'd0);

        finish_run();
    end

endmodule